// File: doc/BRIEF.md
# Serial Character Dot-Map Loader

This block takes bit-mapped 5x7 character data for one half of an eight-character dot display. The data arrives over a three-wire serial link: a data line, a shift clock and a load strobe. All three lines are sampled by the system clock through synchronisers, and their rising edges are detected there. Bits are gathered into 8-bit words. Each word is either an address/control word or a row word of a character frame.

A frame is one address word followed by seven row words for rows 0 to 6. A strap input tells the instance which half of the display it serves: characters 0–3 or characters 4–7. An instance stores the rows of a frame only when the addressed character is in its half. A control word is taken by every instance whatever its strap. Rows go into a 28-entry by 5-bit dot store. The display scanner reads that store through a separate combinational read port.

Top module: `sdl_char_loader`

## Requirements
- R1: Reset clears the 6-bit control register and every dot store entry to zero. It also makes the next complete word be decoded as an address/control word.
- R2: On each synchronised rising edge of `ser_clk`, the level of `ser_data` is shifted in, most significant bit first. On a rising edge of `ser_load`, the word is taken only if exactly 8 bits were shifted since the previous load edge or reset. If any other number of bits was shifted, the bits are discarded and have no effect.
- R3: An address word has bit 7 = 1, and its bits 2:0 give the character number. Bit 2 of that number selects the half: an instance with `half_sel` = 0 owns characters 0–3, and one with `half_sel` = 1 owns characters 4–7. Frames for a character outside the instance's half write nothing to its store.
- R4: The seven words after an address word are rows 0 to 6 in order. For an owned character, each row is written to store index slot × 7 + row, where slot is bits 1:0 of the character number. No other entry changes.
- R5: Only bits 4:0 of a row word are stored. Bits 7:5 are ignored.
- R6: After row 6 of a frame, the next word is decoded as an address/control word again.
- R7: A word in the address position with bit 7 = 0 is a control word. Its bits 5:0 are loaded into the control register whatever `half_sel` is. Row words never change the control register.
- R8: `rd_dots` returns the store entry chosen by `rd_idx` for indices 0–27, and returns zero for indices 28–31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_sel | input | 1 | Strap: 0 serves characters 0–3, 1 serves characters 4–7 |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; its rising edge shifts one bit in |
| ser_load | input | 1 | Load strobe; its rising edge takes the assembled word |
| rd_idx | input | 5 | Dot store read index |
| rd_dots | output | 5 | Dot row at `rd_idx` |
| ctrl_word | output | 6 | Stored control word |

## Verification
Some properties are checked by assertions on every cycle:
- the bit counter never passes its saturation value;
- the row counter stays within rows 0 to 6 and a frame always returns to the address position after row 6;
- row words never disturb the control register;
- store writes stay inside the 28 entries;
- a read port entry holds steady while no write occurs.

Only the bench scenarios can show the rest. These are the MSB-first word order, the dropping of short and long words, and the half decode across two instances with opposite straps. They also cover the masking of row bits 7:5 and the restart of decoding after a reset in the middle of a frame.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_ROWS = 1'b1
    } phase_e;
endpackage

// File: rtl/sdl_line_sync.sv
`timescale 1ns/1ps
// Synchroniser for one asynchronous line plus a rising-edge detector.
module sdl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sdl_word_shift.sv
`timescale 1ns/1ps
// Collects serial bits MSB first; releases a word on a load edge after exactly WORD_W bits.
module sdl_word_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              shift_pulse,
    input  logic              take_pulse,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [WORD_W-1:0] held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (take_pulse) begin
            st_d.valid = (st_q.cnt == CNT_W'(WORD_W));
            st_d.held  = st_q.shreg;
            st_d.cnt   = '0;
        end else if (shift_pulse) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], bit_in};
            if (st_q.cnt != CNT_W'(CNT_SAT))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.held;

    assert_cnt_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_SAT));
    assert_take_restarts_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> st_q.cnt == '0);
endmodule

// File: rtl/sdl_frame_ctrl.sv
`timescale 1ns/1ps
// Decodes address/control words and sequences the seven row words of a frame.
module sdl_frame_ctrl
    import sdl_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ROWS   = 7,
    parameter int DOTS   = 5,
    parameter int WORD_W = 8,
    parameter int CTRL_W = 6,
    parameter int IDX_W  = $clog2(SLOTS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_sel,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DOTS-1:0]   wr_dots,
    output logic [CTRL_W-1:0] ctrl_word
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ROW_W  = $clog2(ROWS + 1);
    localparam int DEPTH  = SLOTS * ROWS;

    typedef struct packed {
        phase_e            phase;
        logic              own;
        logic [SLOT_W-1:0] slot;
        logic [ROW_W-1:0]  row;
        logic [CTRL_W-1:0] ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (word_valid) begin
            if (st_q.phase == PH_ADDR) begin
                if (word[WORD_W-1]) begin
                    st_d.phase = PH_ROWS;
                    st_d.row   = '0;
                    st_d.slot  = word[SLOT_W-1:0];
                    st_d.own   = (word[SLOT_W] == half_sel);
                end else begin
                    st_d.ctrl = word[CTRL_W-1:0];
                end
            end else begin
                if (st_q.row == ROW_W'(ROWS - 1)) begin
                    st_d.phase = PH_ADDR;
                    st_d.row   = '0;
                end else begin
                    st_d.row = st_q.row + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_ADDR, default: '0};
        else        st_q <= st_d;
    end

    assign wr_en     = word_valid && (st_q.phase == PH_ROWS) && st_q.own;
    assign wr_idx    = IDX_W'(st_q.slot) * IDX_W'(ROWS) + IDX_W'(st_q.row);
    assign wr_dots   = word[DOTS-1:0];
    assign ctrl_word = st_q.ctrl;

    logic word_unused;
    assign word_unused = ^word;

    assert_row_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row < ROW_W'(ROWS));
    assert_frame_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && st_q.phase == PH_ROWS && st_q.row == ROW_W'(ROWS - 1))
            |=> st_q.phase == PH_ADDR);
    assert_ctrl_held_in_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && st_q.phase == PH_ROWS) |=> $stable(ctrl_word));
    assert_write_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDX_W'(DEPTH));
endmodule

// File: rtl/sdl_dot_store.sv
`timescale 1ns/1ps
// Dot row store: one synchronous write port, one combinational read port.
module sdl_dot_store #(
    parameter int DEPTH = 28,
    parameter int DOTS  = 5,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DOTS-1:0]  wr_dots,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DOTS-1:0]  rd_dots
);
    logic [DOTS-1:0] mem_d [DEPTH];
    logic [DOTS-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && wr_idx == IDX_W'(i)) mem_d[i] = wr_dots;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_dots = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IDX_W'(i)) rd_dots = mem_q[i];
    end

    assert_store_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en ##1 $stable(rd_idx)) |-> $stable(rd_dots));
endmodule

// File: rtl/sdl_char_loader.sv
`timescale 1ns/1ps
// Top: serial front end, word assembly, frame decode and dot store for one display half.
module sdl_char_loader #(
    parameter int SLOTS       = 4,
    parameter int ROWS        = 7,
    parameter int DOTS        = 5,
    parameter int WORD_W      = 8,
    parameter int CTRL_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                half_sel,
    input  logic                                ser_data,
    input  logic                                ser_clk,
    input  logic                                ser_load,
    input  logic [$clog2(SLOTS*ROWS+4)-1:0]     rd_idx,
    output logic [DOTS-1:0]                     rd_dots,
    output logic [CTRL_W-1:0]                   ctrl_word
);
    localparam int DEPTH   = SLOTS * ROWS;
    localparam int IDX_W   = $clog2(DEPTH + 4);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] line_in, line_lvl, line_rise;
    assign line_in = {ser_load, ser_clk, ser_data};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        sdl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (line_in[g]),
            .level (line_lvl[g]),
            .rise  (line_rise[g])
        );
    end

    logic lines_unused;
    assign lines_unused = ^{line_lvl[2:1], line_rise[0]};

    logic              word_valid;
    logic [WORD_W-1:0] word;

    sdl_word_shift #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (line_lvl[0]),
        .shift_pulse (line_rise[1]),
        .take_pulse  (line_rise[2]),
        .word_valid  (word_valid),
        .word        (word)
    );

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DOTS-1:0]  wr_dots;

    sdl_frame_ctrl #(
        .SLOTS(SLOTS), .ROWS(ROWS), .DOTS(DOTS),
        .WORD_W(WORD_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_sel   (half_sel),
        .word_valid (word_valid),
        .word       (word),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_dots    (wr_dots),
        .ctrl_word  (ctrl_word)
    );

    sdl_dot_store #(.DEPTH(DEPTH), .DOTS(DOTS), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_dots (wr_dots),
        .rd_idx  (rd_idx),
        .rd_dots (rd_dots)
    );
endmodule

// File: tb/sdl_char_loader_test.sv
`timescale 1ns/1ps
module sdl_char_loader_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic [4:0] rd_idx = '0;
    logic [4:0] rd_lo, rd_hi;
    logic [5:0] ctrl_lo, ctrl_hi;

    sdl_char_loader uut (
        .clk(clk), .rst_n(rst_n), .half_sel(1'b0),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
        .rd_idx(rd_idx), .rd_dots(rd_lo), .ctrl_word(ctrl_lo)
    );
    sdl_char_loader uut_hi (
        .clk(clk), .rst_n(rst_n), .half_sel(1'b1),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
        .rd_idx(rd_idx), .rd_dots(rd_hi), .ctrl_word(ctrl_hi)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [4:0] exp_lo [28];
    logic [4:0] exp_hi [28];

    // Frames: address word in [63:56], rows 0..6 below it.
    localparam logic [63:0] VEC [4] = '{
        {8'h81, 8'h1F, 8'h11, 8'h15, 8'h0A, 8'h04, 8'h1B, 8'h0E},
        {8'h86, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h03, 8'h1C},
        {8'h83, 8'hE5, 8'h3F, 8'h7F, 8'h9A, 8'h00, 8'hFF, 8'h41},
        {8'h8C, 8'h12, 8'h0C, 8'hB3, 8'h07, 8'h19, 8'h06, 8'h15}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
        end
        tick(3);
        ser_load = 1'b1;
        tick(3);
        ser_load = 1'b0;
        tick(6);
    endtask

    task automatic send_word(input logic [7:0] w);
        send_bits({8'h00, w}, 8);
    endtask

    task automatic send_frame(input logic [63:0] f);
        logic [2:0] ch;
        ch = f[58:56];
        for (int b = 7; b >= 0; b--) send_word(f[b*8 +: 8]);
        for (int r = 0; r < 7; r++) begin
            if (ch[2]) exp_hi[ch[1:0]*7 + r] = f[(6-r)*8 +: 5];
            else       exp_lo[ch[1:0]*7 + r] = f[(6-r)*8 +: 5];
        end
    endtask

    task automatic check_store(input string tag);
        for (int i = 0; i < 28; i++) begin
            rd_idx = 5'(i);
            tick(1);
            check({tag, " lo"}, rd_lo, exp_lo[i]);
            check({tag, " hi"}, rd_hi, exp_hi[i]);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 28; i++) begin exp_lo[i] = '0; exp_hi[i] = '0; end
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check("R1 ctrl lo", ctrl_lo, 0);
        check("R1 ctrl hi", ctrl_hi, 0);
        check_store("R1 store");

        // R7: control word taken by both halves
        send_word(8'h2A);
        check("R7 ctrl lo", ctrl_lo, 'h2A);
        check("R7 ctrl hi", ctrl_hi, 'h2A);

        // R3 R4 R5: frame table walk
        for (int v = 0; v < 4; v++) begin
            send_frame(VEC[v]);
            check("R7 rows keep ctrl lo", ctrl_lo, 'h2A);
            check("R7 rows keep ctrl hi", ctrl_hi, 'h2A);
        end
        check_store("R3 R4 R5 store");

        // R6: word after row 6 is an address/control word
        send_word(8'h75);
        check("R6 ctrl lo", ctrl_lo, 'h35);
        check("R6 ctrl hi", ctrl_hi, 'h35);

        // R2: short and long words are dropped
        send_bits(16'h0003, 5);
        check("R2 short ctrl", ctrl_lo, 'h35);
        send_bits(16'h0001, 10);
        check("R2 long ctrl", ctrl_lo, 'h35);
        send_word(8'h0C);
        check("R2 msb first", ctrl_lo, 'h0C);
        check_store("R2 store untouched");

        // R4: rewrite of one slot leaves neighbours
        send_frame({8'h81, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06});
        check_store("R4 rewrite");

        // R8: out-of-range read gives zero
        rd_idx = 5'd28; tick(1);
        check("R8 idx28", rd_lo, 0);
        rd_idx = 5'd31; tick(1);
        check("R8 idx31", rd_hi, 0);

        // R1: reset in mid-frame
        send_word(8'h80);
        send_word(8'h1F);
        send_word(8'h1F);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        for (int i = 0; i < 28; i++) begin exp_lo[i] = '0; exp_hi[i] = '0; end
        check("R1 ctrl after reset", ctrl_lo, 0);
        check_store("R1 store after reset");
        send_word(8'h09);
        check("R1 addr position lo", ctrl_lo, 'h09);
        check("R1 addr position hi", ctrl_hi, 'h09);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule